// File: doc/BRIEF.md
# Word Stream to Ethernet Frame Bridge

This block carries 32-bit words between two directly cabled boards over a byte-wide Ethernet MAC. On the transmit side, words written into a FIFO-like input port are collected into a frame buffer. When the buffer holds the largest permitted number of words, or when the input has been quiet for a programmable number of cycles, the buffer is sent as one frame. Each frame carries the remote and local MAC addresses, a fixed EtherType and a 16-bit length header, and is padded with zeros when the payload would otherwise be shorter than the Ethernet minimum.

On the receive side, bytes from the MAC are parsed. Frames whose EtherType differs from the configured value are discarded. In accepted frames the block reads the length header, rebuilds 32-bit words from the payload and pushes them into an output FIFO with first-word-fall-through reads. The MAC appends and checks the frame check sequence. There is no acknowledgement or retransmission: the link is assumed to deliver frames reliably and in order, and a reader that falls behind loses words.

Top module: `wordlink_eth_bridge`

## Requirements
- R1: Transmitted bytes 0-5 are `cfg_remote_mac` and bytes 6-11 are `cfg_local_mac`, each sent most significant byte first.
- R2: Bytes 12-13 of every transmitted frame carry the parameter `ETH_TYPE`, high byte first.
- R3: Bytes 14-15 are a big-endian length header. It equals 4·n, where n is the word count, when 2+4·n is below 46, and it is 0 otherwise.
- R4: Starting at byte 16, the buffered words are sent in the order they were written, each one most significant byte first.
- R5: A frame with 2+4·n below 46 is zero-padded to 60 bytes in total. Any other frame is exactly 16+4·n bytes. `tx_last` marks the final byte, and `tx_data`/`tx_last` hold steady while `tx_valid` is high and `tx_ready` is low.
- R6: When the MAX_WORDS-th word is written, the frame is launched and `in_full` is high from the next cycle until the final byte has been accepted. Bytes of a frame leave back to back whenever `tx_ready` is high.
- R7: A partial frame is launched exactly `cfg_idle_limit`+1 cycles after its last accepted write, provided no further word is written in that time. `in_full` stays low while the frame is still collecting.
- R8: Received payload words appear on `out_data` in arrival order with `out_exists` high. The head word stays unchanged until `out_rd` pops it.
- R9: A received frame whose bytes 12-13 differ from `ETH_TYPE` produces no output word.
- R10: A non-zero received length header limits forwarding to that many payload bytes. A zero header forwards every payload word up to `rx_last`.
- R11: Trailing received payload bytes that do not complete a 32-bit word are discarded.
- R12: Words that arrive while the output FIFO is full are dropped. The words already stored are kept intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_local_mac | input | 48 | Address of this board, sent as the source |
| cfg_remote_mac | input | 48 | Address of the far board, sent as the destination |
| cfg_idle_limit | input | IDLE_W | Quiet cycles before a partial frame is launched |
| in_wr | input | 1 | Write strobe of the input stream |
| in_data | input | 32 | Input word |
| in_full | output | 1 | Input cannot accept a word |
| out_rd | input | 1 | Pops the head of the output stream |
| out_data | output | 32 | Head word of the output stream |
| out_exists | output | 1 | Output stream holds at least one word |
| tx_data | output | 8 | Transmit byte to the MAC |
| tx_valid | output | 1 | Transmit byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the transmit byte |
| rx_data | input | 8 | Received byte from the MAC |
| rx_valid | input | 1 | Received byte valid |
| rx_last | input | 1 | Final received byte of the frame (with rx_valid) |

## Verification
The bench loops the transmit port back into the receive port and sends random bursts under random MAC backpressure. The bursts include lengths of 10 and 11 words, which sit on either side of the padding threshold. A wrong threshold shows up as a bad length header or as padding bytes delivered as data. Full bursts check that launch happens at the word limit and not one word late. Partial bursts check the exact idle delay, so a counter that is off by one is caught. Injected frames cover a wrong EtherType, which would otherwise leak words, and a short length header followed by junk, which a receiver that ignores the header would forward. They also cover trailing odd bytes, which would be forwarded as half-filled words, and an output overflow, which would corrupt stored words or keep the extra ones.

// File: rtl/wlb_pkg.sv
package wlb_pkg;
    localparam int HDR_BYTES   = 16;
    localparam int MIN_PAYLOAD = 46;
    localparam int MIN_FRAME   = 60;
    localparam int RX_POS_W    = 11;

    typedef enum logic {
        TX_COLLECT = 1'b0,
        TX_SEND    = 1'b1
    } tx_state_e;
endpackage

// File: rtl/wlb_word_fifo.sv
module wlb_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 512
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [AW:0]   cnt;
    } fifo_regs_t;

    fifo_regs_t r_q, r_d;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        r_d     = r_q;
        push_ok = push && (r_q.cnt != (AW+1)'(DEPTH));
        pop_ok  = pop && (r_q.cnt != '0);
        if (push_ok) r_d.wr = r_q.wr + 1'b1;
        if (pop_ok)  r_d.rd = r_q.rd + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[r_q.wr] <= push_data;
    end

    assign head      = mem_q[r_q.rd];
    assign not_empty = (r_q.cnt != '0);
endmodule

// File: rtl/wlb_tx_framer.sv
module wlb_tx_framer
    import wlb_pkg::*;
#(
    parameter int          MAX_WORDS = 374,
    parameter int          IDLE_W    = 16,
    parameter logic [15:0] ETH_TYPE  = 16'h88B5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [47:0]       local_mac,
    input  logic [47:0]       remote_mac,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              in_wr,
    input  logic [31:0]       in_data,
    output logic              in_full,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready
);
    localparam int CNT_W  = $clog2(MAX_WORDS + 1);
    localparam int IDX_W  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
    localparam int BYTE_W = $clog2(HDR_BYTES + 4 * MAX_WORDS + MIN_FRAME);

    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  count;
        logic [IDLE_W-1:0] idle;
        logic [BYTE_W-1:0] pos;
    } tx_regs_t;

    tx_regs_t r_q, r_d;
    logic [31:0] buf_q [MAX_WORDS];

    logic              wr_ok, launch;
    logic [BYTE_W-1:0] data_bytes, frame_bytes, doff, wsel;
    logic [15:0]       len_hdr;
    logic [127:0]      hdr, hdr_sh;
    logic [IDX_W-1:0]  widx;
    logic [31:0]       rword;
    logic [7:0]        wbyte;

    always_comb begin
        data_bytes  = BYTE_W'(r_q.count) << 2;
        len_hdr     = ((data_bytes + BYTE_W'(2)) < BYTE_W'(MIN_PAYLOAD)) ? 16'(data_bytes) : 16'd0;
        frame_bytes = ((data_bytes + BYTE_W'(HDR_BYTES)) < BYTE_W'(MIN_FRAME)) ?
                      BYTE_W'(MIN_FRAME) : data_bytes + BYTE_W'(HDR_BYTES);
        hdr     = {remote_mac, local_mac, ETH_TYPE, len_hdr};
        hdr_sh  = hdr << {r_q.pos[3:0], 3'b000};
        doff    = r_q.pos - BYTE_W'(HDR_BYTES);
        wsel    = doff >> 2;
        widx    = IDX_W'(wsel);
        rword   = buf_q[widx];
        case (doff[1:0])
            2'd0:    wbyte = rword[31:24];
            2'd1:    wbyte = rword[23:16];
            2'd2:    wbyte = rword[15:8];
            default: wbyte = rword[7:0];
        endcase
        if (r_q.pos < BYTE_W'(HDR_BYTES))                    tx_data = hdr_sh[127:120];
        else if (r_q.pos < data_bytes + BYTE_W'(HDR_BYTES))  tx_data = wbyte;
        else                                                 tx_data = 8'h00;
        tx_valid = (r_q.state == TX_SEND);
        tx_last  = tx_valid && (r_q.pos == frame_bytes - 1'b1);
        in_full  = (r_q.state == TX_SEND);
    end

    always_comb begin
        r_d    = r_q;
        wr_ok  = 1'b0;
        launch = 1'b0;
        case (r_q.state)
            TX_COLLECT: begin
                wr_ok = in_wr;
                if (in_wr) begin
                    r_d.count = r_q.count + 1'b1;
                    r_d.idle  = '0;
                end else if (r_q.count != '0 && r_q.idle != idle_limit) begin
                    r_d.idle = r_q.idle + 1'b1;
                end
                launch = (r_d.count == CNT_W'(MAX_WORDS)) ||
                         (r_q.count != '0 && r_q.idle == idle_limit);
                if (launch) begin
                    r_d.state = TX_SEND;
                    r_d.pos   = '0;
                    r_d.idle  = '0;
                end
            end
            default: begin
                if (tx_ready) begin
                    if (tx_last) begin
                        r_d.state = TX_COLLECT;
                        r_d.count = '0;
                        r_d.pos   = '0;
                    end else begin
                        r_d.pos = r_q.pos + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: TX_COLLECT, count: '0, idle: '0, pos: '0};
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) buf_q[r_q.count[IDX_W-1:0]] <= in_data;
    end
endmodule

// File: rtl/wlb_rx_deframer.sv
module wlb_rx_deframer
    import wlb_pkg::*;
#(
    parameter logic [15:0] ETH_TYPE = 16'h88B5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_last,
    output logic        word_push,
    output logic [31:0] word_data
);
    typedef struct packed {
        logic [RX_POS_W-1:0] pos;
        logic [7:0]          type_hi;
        logic [15:0]         len;
        logic                drop;
        logic [23:0]         shreg;
        logic                push;
        logic [31:0]         word;
    } rx_regs_t;

    rx_regs_t r_q, r_d;
    logic [RX_POS_W-1:0] doff;
    logic                keep;

    always_comb begin
        r_d      = r_q;
        r_d.push = 1'b0;
        doff     = r_q.pos - RX_POS_W'(HDR_BYTES);
        keep     = (r_q.len == 16'd0) || (16'(doff) < r_q.len);
        if (rx_valid) begin
            if (r_q.pos == RX_POS_W'(12)) r_d.type_hi = rx_data;
            if (r_q.pos == RX_POS_W'(13) && {r_q.type_hi, rx_data} != ETH_TYPE) r_d.drop = 1'b1;
            if (r_q.pos == RX_POS_W'(14)) r_d.len[15:8] = rx_data;
            if (r_q.pos == RX_POS_W'(15)) r_d.len[7:0]  = rx_data;
            if (r_q.pos >= RX_POS_W'(HDR_BYTES)) begin
                r_d.shreg = {r_q.shreg[15:0], rx_data};
                if (!r_q.drop && doff[1:0] == 2'd3 && keep) begin
                    r_d.push = 1'b1;
                    r_d.word = {r_q.shreg, rx_data};
                end
            end
            if (r_q.pos != '1) r_d.pos = r_q.pos + 1'b1;
            if (rx_last) begin
                r_d.pos  = '0;
                r_d.drop = 1'b0;
                r_d.len  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign word_push = r_q.push;
    assign word_data = r_q.word;
endmodule

// File: rtl/wordlink_eth_bridge.sv
module wordlink_eth_bridge #(
    parameter int          MAX_WORDS = 374,
    parameter int          OUT_DEPTH = 512,
    parameter int          IDLE_W    = 16,
    parameter logic [15:0] ETH_TYPE  = 16'h88B5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [47:0]       cfg_local_mac,
    input  logic [47:0]       cfg_remote_mac,
    input  logic [IDLE_W-1:0] cfg_idle_limit,
    input  logic              in_wr,
    input  logic [31:0]       in_data,
    output logic              in_full,
    input  logic              out_rd,
    output logic [31:0]       out_data,
    output logic              out_exists,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_last
);
    logic        rx_push;
    logic [31:0] rx_word;

    wlb_tx_framer #(
        .MAX_WORDS (MAX_WORDS),
        .IDLE_W    (IDLE_W),
        .ETH_TYPE  (ETH_TYPE)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_mac  (cfg_local_mac),
        .remote_mac (cfg_remote_mac),
        .idle_limit (cfg_idle_limit),
        .in_wr      (in_wr),
        .in_data    (in_data),
        .in_full    (in_full),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready)
    );

    wlb_rx_deframer #(
        .ETH_TYPE (ETH_TYPE)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_last   (rx_last),
        .word_push (rx_push),
        .word_data (rx_word)
    );

    wlb_word_fifo #(
        .W     (32),
        .DEPTH (OUT_DEPTH)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_word),
        .pop       (out_rd),
        .head      (out_data),
        .not_empty (out_exists)
    );
endmodule

// File: rtl/wordlink_eth_bridge_chk.sv
module wordlink_eth_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        out_rd,
    input logic        out_exists,
    input logic [31:0] out_data,
    input logic [7:0]  tx_data,
    input logic        tx_valid,
    input logic        tx_last,
    input logic        tx_ready
);
    // R5
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R6
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_last) |=> tx_valid);

    // R6
    reopen_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_exists && !out_rd) |=> (out_exists && $stable(out_data)));
endmodule

bind wordlink_eth_bridge wordlink_eth_bridge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_rd     (out_rd),
    .out_exists (out_exists),
    .out_data   (out_data),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .tx_ready   (tx_ready)
);

// File: tb/wordlink_eth_bridge_bench.sv
`timescale 1ns/1ps
module wordlink_eth_bridge_bench;
    localparam int          MAXW  = 16;
    localparam int          DEPTH = 4;
    localparam int          IDLE  = 6;
    localparam logic [15:0] ETYPE = 16'h88B5;
    localparam logic [47:0] LMAC  = 48'h02_11_22_33_44_55;
    localparam logic [47:0] RMAC  = 48'h02_AA_BB_CC_DD_EE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_wr = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_full;
    logic        rd_en = 1'b1;
    logic [31:0] out_data;
    logic        out_exists;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b1;
    logic        loop_en = 1'b1;
    logic [7:0]  inj_data = '0;
    logic        inj_valid = 1'b0, inj_last = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_last;

    assign rx_data  = loop_en ? tx_data : inj_data;
    assign rx_valid = loop_en ? (tx_valid && tx_ready) : inj_valid;
    assign rx_last  = loop_en ? tx_last : inj_last;

    always #5 clk = ~clk;

    wordlink_eth_bridge #(
        .MAX_WORDS (MAXW),
        .OUT_DEPTH (DEPTH),
        .IDLE_W    (8),
        .ETH_TYPE  (ETYPE)
    ) u_wordlink_eth_bridge (
        .clk(clk), .rst_n(rst_n),
        .cfg_local_mac(LMAC), .cfg_remote_mac(RMAC), .cfg_idle_limit(8'(IDLE)),
        .in_wr(in_wr), .in_data(in_data), .in_full(in_full),
        .out_rd(rd_en), .out_data(out_data), .out_exists(out_exists),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int frames_done = 0;
    int fpos = 0;
    int cur_n = 0;
    int last_wr_cyc = 0, vcyc = 0;
    bit vseen = 1'b0;
    bit ready_rand = 1'b0;
    string rtag = "R8";
    logic [31:0] cur_words [MAXW];
    logic [7:0]  fb [128];
    logic [7:0]  inj [128];
    logic [31:0] exp_rx [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_tx_byte(input int i, input int n);
        logic [127:0] h;
        int plen;
        plen = (2 + 4 * n < 46) ? 4 * n : 0;
        h = {RMAC, LMAC, ETYPE, 16'(plen)};
        if (i < 16) return h[127 - 8 * i -: 8];
        if (i < 16 + 4 * n) return cur_words[(i - 16) / 4][31 - 8 * ((i - 16) % 4) -: 8];
        return 8'h00;
    endfunction

    function automatic string byte_req(input int i, input int n);
        if (i < 12) return "R1";
        if (i < 14) return "R2";
        if (i < 16) return "R3";
        if (i < 16 + 4 * n) return "R4";
        return "R5";
    endfunction

    task automatic check_frame(input int nbytes);
        int exp_len;
        exp_len = (16 + 4 * cur_n < 60) ? 60 : 16 + 4 * cur_n;
        chk(nbytes == exp_len, "R5", "frame length", nbytes, exp_len);
        for (int i = 0; i < nbytes && i < 128; i++)
            chk(fb[i] == exp_tx_byte(i, cur_n), byte_req(i, cur_n), $sformatf("byte %0d", i),
                fb[i], exp_tx_byte(i, cur_n));
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (in_wr && !in_full) last_wr_cyc = cyc + 1;
            if (tx_valid && !vseen) begin
                vseen = 1'b1;
                vcyc  = cyc;
            end
            if (tx_valid && tx_ready) begin
                if (fpos < 128) fb[fpos] = tx_data;
                fpos++;
                if (tx_last) begin
                    check_frame(fpos);
                    if (cur_n < MAXW)
                        chk(vcyc - last_wr_cyc == IDLE + 1, "R7", "idle launch delay",
                            vcyc - last_wr_cyc, IDLE + 1);
                    fpos  = 0;
                    vseen = 1'b0;
                    frames_done++;
                end
            end
            if (out_exists && rd_en) begin
                if (exp_rx.size() == 0) begin
                    chk(1'b0, rtag, "unexpected output word", out_data, 0);
                end else begin
                    logic [31:0] e;
                    e = exp_rx.pop_front();
                    chk(out_data == e, rtag, "output word", out_data, e);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            tx_ready = ready_rand ? ($urandom_range(3) != 0) : 1'b1;
        end
    end

    task automatic send_burst(input int n);
        int prev;
        prev  = frames_done;
        cur_n = n;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_wr   = 1'b1;
            in_data = $urandom();
            cur_words[i] = in_data;
            exp_rx.push_back(in_data);
        end
        @(posedge clk); #1;
        in_wr = 1'b0;
        @(negedge clk);
        if (n == MAXW) chk(in_full == 1'b1, "R6", "in_full after last word", in_full, 1);
        else           chk(in_full == 1'b0, "R7", "in_full while collecting", in_full, 0);
        while (frames_done == prev) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic inj_frame(input int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            @(posedge clk); #1;
            inj_valid = 1'b1;
            inj_data  = inj[i];
            inj_last  = (i == nbytes - 1);
        end
        @(posedge clk); #1;
        inj_valid = 1'b0;
        inj_last  = 1'b0;
    endtask

    task automatic build_hdr(input logic [15:0] ty, input logic [15:0] len);
        logic [127:0] h;
        h = {LMAC, RMAC, ty, len};
        for (int i = 0; i < 16; i++) inj[i] = h[127 - 8 * i -: 8];
    endtask

    task automatic wait_drain();
        int t;
        t = 0;
        while (exp_rx.size() != 0 && t < 2000) begin
            @(posedge clk);
            t++;
        end
        chk(exp_rx.size() == 0, rtag, "words still expected", exp_rx.size(), 0);
        repeat (5) @(posedge clk);
    endtask

    initial begin
        int lens [6] = '{1, 10, 11, 16, 3, 16};
        void'($urandom(32'd7319));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(in_full == 1'b0, "R6", "reset in_full", in_full, 0);
        chk(tx_valid == 1'b0, "R6", "reset tx_valid", tx_valid, 0);
        chk(out_exists == 1'b0, "R8", "reset out_exists", out_exists, 0);

        rtag = "R8";
        foreach (lens[i]) send_burst(lens[i]);
        ready_rand = 1'b1;
        for (int k = 0; k < 30; k++) send_burst($urandom_range(MAXW, 1));
        ready_rand = 1'b0;
        wait_drain();

        loop_en = 1'b0;
        // R9: wrong type, eight payload words
        rtag = "R9";
        build_hdr(16'h1234, 16'd0);
        for (int i = 16; i < 48; i++) inj[i] = 8'(i);
        inj_frame(48);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(out_exists == 1'b0, "R9", "out_exists after foreign type", out_exists, 0);

        // R10: header says 8 bytes, followed by junk padding
        rtag = "R10";
        build_hdr(ETYPE, 16'd8);
        for (int i = 16; i < 60; i++) inj[i] = 8'(8'hA0 + i);
        exp_rx.push_back({inj[16], inj[17], inj[18], inj[19]});
        exp_rx.push_back({inj[20], inj[21], inj[22], inj[23]});
        inj_frame(60);
        wait_drain();

        // R11: zero header, three words plus two stray bytes
        rtag = "R11";
        build_hdr(ETYPE, 16'd0);
        for (int i = 16; i < 30; i++) inj[i] = 8'($urandom());
        exp_rx.push_back({inj[16], inj[17], inj[18], inj[19]});
        exp_rx.push_back({inj[20], inj[21], inj[22], inj[23]});
        exp_rx.push_back({inj[24], inj[25], inj[26], inj[27]});
        inj_frame(30);
        wait_drain();

        // R12: six words into a four-deep output with reads held off
        rtag = "R12";
        rd_en = 1'b0;
        build_hdr(ETYPE, 16'd0);
        for (int i = 16; i < 40; i++) inj[i] = 8'($urandom());
        for (int w = 0; w < DEPTH; w++)
            exp_rx.push_back({inj[16+4*w], inj[17+4*w], inj[18+4*w], inj[19+4*w]});
        inj_frame(40);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(out_exists == 1'b1, "R12", "out_exists while held", out_exists, 1);
        chk(out_data == exp_rx[0], "R12", "head word while held", out_data, exp_rx[0]);
        @(posedge clk); #1 rd_en = 1'b1;
        wait_drain();
        @(negedge clk);
        chk(out_exists == 1'b0, "R12", "out_exists after drain", out_exists, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule